// File: doc/BRIEF.md
# DRAM ECC Error Log Registers

This block sits beside the ECC checker of a two-channel DRAM controller. It records each kind of error event in a sticky status flag. These are correctable (single-bit) ECC errors, uncorrectable (multi-bit) ECC errors, refresh timeouts, locked accesses that target non-DRAM space, and thermal sensor events. For ECC errors it also keeps the failing address, the channel and the syndrome. Software reads and clears these registers through a simple indexed register port. A per-flag enable register decides which flags drive the system-error output `serr`.

The log is built so that its contents stay useful. The first error of a class is kept until software clears its flag. An uncorrectable error replaces a logged correctable one. A correctable error never replaces a logged uncorrectable one. The address is kept at 128-byte granularity, so the checker supplies only address bits 32 down to 7.

Register indices on `reg_addr`: 0 status, 1 command (SERR enables), 2 error pointer, 3 extended pointer, 4 syndrome. Reads are combinational from registered state. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `ecc_err_log`

## Requirements
- R1: Status (index 0) bit 0 is set by `ce_stb`, bit 1 by `ue_stb`, bit 8 by `rfto_stb`, bit 9 by `lock_stb` and bit 11 by `therm_stb`, one cycle after the strobe. All other status bits read 0. Status and command reset to 0.
- R2: Writing status with a 1 in a flag position clears that flag, and a 0 leaves it unchanged. If a strobe sets a flag in the same cycle as the clear, the flag ends up set.
- R3: The error pointer (index 2) reads logged address bits 31:7 in bits 31:7, zeros in bits 6:1, and the logged channel in bit 0.
- R4: The extended pointer (index 3) reads logged address bit 32 in bit 0 and zeros in bits 31:1.
- R5: The syndrome register (index 4) reads the logged 8-bit syndrome in bits 7:0 and zeros above.
- R6: The command register (index 1) is written directly. Only bits 0, 1, 8, 9 and 11 are stored, and all other bits read 0.
- R7: `serr` is high exactly when some status flag is set and its command bit at the same position is set.
- R8: An uncorrectable error that arrives while the uncorrectable flag is clear logs its address, channel and syndrome, even if a correctable error is already logged.
- R9: While the uncorrectable flag is set, a correctable error sets bit 0 but leaves the log unchanged.
- R10: While a flag is set, a further error of the same class leaves the log unchanged. Once the flag is cleared, the next error of that class is logged.
- R11: A correctable and an uncorrectable strobe in the same cycle set both flags, and the log takes that cycle's error data.
- R12: Writes to indices 2 to 7 have no effect, and indices 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_stb | input | 1 | Correctable ECC error strobe |
| ue_stb | input | 1 | Uncorrectable ECC error strobe |
| err_addr | input | 26 | Error address bits 32:7 |
| err_chan | input | 1 | Channel of the error |
| err_syn | input | 8 | ECC syndrome of the error |
| rfto_stb | input | 1 | Refresh timeout strobe |
| lock_stb | input | 1 | Locked access to non-DRAM space strobe |
| therm_stb | input | 1 | Thermal sensor event strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data |
| serr | output | 1 | System error output |

## Verification
The assertions check every cycle that each strobe sets its flag, that a write of 1 clears a flag when no strobe competes, that an unmasked flag drives `serr` and a fully masked set does not, and that the log loads on a fresh uncorrectable error and holds on a correctable error that follows one. The bench scenarios cover the results that need a sequence of events to show: read layouts with reserved zeros, the first-error-kept rule across a clear, a correctable log replaced by an uncorrectable one, a same-cycle set and clear, and writes to the read-only registers having no effect.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    localparam int STAT_W = 16;
    localparam logic [STAT_W-1:0] STAT_MASK = 16'h0B03;
    localparam int B_CE    = 0;
    localparam int B_UE    = 1;
    localparam int B_RFTO  = 8;
    localparam int B_LOCK  = 9;
    localparam int B_THERM = 11;
    localparam int IDX_W   = 3;
    localparam int RD_W    = 32;

    typedef enum logic [IDX_W-1:0] {
        IDX_STAT = 3'd0,
        IDX_CMD  = 3'd1,
        IDX_PTR  = 3'd2,
        IDX_EXT  = 3'd3,
        IDX_SYN  = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         cmd_we_i,
    input  logic [W-1:0] cmd_wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] cmd_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] cmd;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        // a set in the same cycle overrides the write-one clear
        bank_d.stat = ((bank_q.stat & ~clr_i) | set_i) & MASK;
        if (cmd_we_i) begin
            bank_d.cmd = cmd_wdata_i & MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.stat;
    assign cmd_o  = bank_q.cmd;
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
    parameter int HI_W  = 25,
    parameter int EXT_W = 1,
    parameter int SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_stb_i,
    input  logic             ue_stb_i,
    input  logic             ce_held_i,
    input  logic             ue_held_i,
    input  logic [HI_W-1:0]  hi_i,
    input  logic [EXT_W-1:0] ext_i,
    input  logic             chan_i,
    input  logic [SYN_W-1:0] syn_i,
    output logic [HI_W-1:0]  hi_o,
    output logic [EXT_W-1:0] ext_o,
    output logic             chan_o,
    output logic [SYN_W-1:0] syn_o
);
    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [EXT_W-1:0] ext;
        logic             chan;
        logic [SYN_W-1:0] syn;
    } log_t;

    log_t log_d, log_q;
    logic take_ue, take_ce;

    always_comb begin
        // uncorrectable wins over any correctable log; correctable only
        // loads into an empty log with no uncorrectable pending
        take_ue = ue_stb_i && !ue_held_i;
        take_ce = ce_stb_i && !ce_held_i && !ue_held_i && !ue_stb_i;
        log_d   = log_q;
        if (take_ue || take_ce) begin
            log_d.hi   = hi_i;
            log_d.ext  = ext_i;
            log_d.chan = chan_i;
            log_d.syn  = syn_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

    assign hi_o   = log_q.hi;
    assign ext_o  = log_q.ext;
    assign chan_o = log_q.chan;
    assign syn_o  = log_q.syn;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce_stb,
    input  logic                        ue_stb,
    input  logic [ADDR_W-1:GRAIN_LSB]   err_addr,
    input  logic                        err_chan,
    input  logic [SYN_W-1:0]            err_syn,
    input  logic                        rfto_stb,
    input  logic                        lock_stb,
    input  logic                        therm_stb,
    input  logic                        reg_wr,
    input  logic [IDX_W-1:0]            reg_addr,
    input  logic [STAT_W-1:0]           reg_wdata,
    output logic [RD_W-1:0]             reg_rdata,
    output logic                        serr
);
    localparam int HI_W  = 32 - GRAIN_LSB;
    localparam int EXT_W = ADDR_W - 32;
    localparam int PAD_W = GRAIN_LSB - 1;

    logic [STAT_W-1:0] set_vec, clr_vec, stat_q, cmd_q;
    logic              wr_stat, wr_cmd;
    logic [HI_W-1:0]   hi_q;
    logic [EXT_W-1:0]  ext_q;
    logic              chan_q;
    logic [SYN_W-1:0]  syn_q;

    always_comb begin
        wr_stat = reg_wr && (reg_addr == IDX_STAT);
        wr_cmd  = reg_wr && (reg_addr == IDX_CMD);
        clr_vec = wr_stat ? reg_wdata : '0;
        set_vec          = '0;
        set_vec[B_CE]    = ce_stb;
        set_vec[B_UE]    = ue_stb;
        set_vec[B_RFTO]  = rfto_stb;
        set_vec[B_LOCK]  = lock_stb;
        set_vec[B_THERM] = therm_stb;
    end

    ecc_flag_bank #(
        .W    (STAT_W),
        .MASK (STAT_MASK)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_vec),
        .clr_i       (clr_vec),
        .cmd_we_i    (wr_cmd),
        .cmd_wdata_i (reg_wdata),
        .stat_o      (stat_q),
        .cmd_o       (cmd_q)
    );

    ecc_log_capture #(
        .HI_W  (HI_W),
        .EXT_W (EXT_W),
        .SYN_W (SYN_W)
    ) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_stb_i  (ce_stb),
        .ue_stb_i  (ue_stb),
        .ce_held_i (stat_q[B_CE] && !clr_vec[B_CE]),
        .ue_held_i (stat_q[B_UE] && !clr_vec[B_UE]),
        .hi_i      (err_addr[31:GRAIN_LSB]),
        .ext_i     (err_addr[ADDR_W-1:32]),
        .chan_i    (err_chan),
        .syn_i     (err_syn),
        .hi_o      (hi_q),
        .ext_o     (ext_q),
        .chan_o    (chan_q),
        .syn_o     (syn_q)
    );

    always_comb begin
        case (reg_addr)
            IDX_STAT: reg_rdata = {{(RD_W-STAT_W){1'b0}}, stat_q};
            IDX_CMD:  reg_rdata = {{(RD_W-STAT_W){1'b0}}, cmd_q};
            IDX_PTR:  reg_rdata = {hi_q, {PAD_W{1'b0}}, chan_q};
            IDX_EXT:  reg_rdata = {{(RD_W-EXT_W){1'b0}}, ext_q};
            IDX_SYN:  reg_rdata = {{(RD_W-SYN_W){1'b0}}, syn_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign serr = |(stat_q & cmd_q);
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ce_stb,
    input logic                      ue_stb,
    input logic [ADDR_W-1:GRAIN_LSB] err_addr,
    input logic [SYN_W-1:0]          err_syn,
    input logic                      reg_wr,
    input logic [IDX_W-1:0]          reg_addr,
    input logic [STAT_W-1:0]         reg_wdata,
    input logic                      serr,
    input logic [STAT_W-1:0]         stat_q,
    input logic [STAT_W-1:0]         cmd_q,
    input logic [31-GRAIN_LSB:0]     hi_q,
    input logic [SYN_W-1:0]          syn_q
);
    logic clr_ce, clr_ue;
    assign clr_ce = reg_wr && (reg_addr == IDX_STAT) && reg_wdata[B_CE];
    assign clr_ue = reg_wr && (reg_addr == IDX_STAT) && reg_wdata[B_UE];

    p_ce_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_stb |=> stat_q[B_CE]);

    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ce && !ce_stb) |=> !stat_q[B_CE]);

    p_serr_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[B_UE] && cmd_q[B_UE]) |-> serr);

    p_serr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & cmd_q) == '0) |-> !serr);

    p_ue_log_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_stb && !stat_q[B_UE]) |=>
            (hi_q == $past(err_addr[31:GRAIN_LSB])) && (syn_q == $past(err_syn)));

    p_ce_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_stb && !ue_stb && stat_q[B_UE] && !clr_ue) |=>
            ($stable(hi_q) && $stable(syn_q)));

    p_repeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_stb && !ue_stb && stat_q[B_CE] && !clr_ce) |=>
            ($stable(hi_q) && $stable(syn_q)));
endmodule

bind ecc_err_log ecc_err_log_chk #(
    .ADDR_W    (ADDR_W),
    .GRAIN_LSB (GRAIN_LSB),
    .SYN_W     (SYN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_stb    (ce_stb),
    .ue_stb    (ue_stb),
    .err_addr  (err_addr),
    .err_syn   (err_syn),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .serr      (serr),
    .stat_q    (stat_q),
    .cmd_q     (cmd_q),
    .hi_q      (hi_q),
    .syn_q     (syn_q)
);

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_stb = 1'b0, ue_stb = 1'b0;
    logic [32:7] err_addr = '0;
    logic        err_chan = 1'b0;
    logic [7:0]  err_syn = '0;
    logic        rfto_stb = 1'b0, lock_stb = 1'b0, therm_stb = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ecc_err_log i_ecc_err_log (
        .clk(clk), .rst_n(rst_n), .ce_stb(ce_stb), .ue_stb(ue_stb),
        .err_addr(err_addr), .err_chan(err_chan), .err_syn(err_syn),
        .rfto_stb(rfto_stb), .lock_stb(lock_stb), .therm_stb(therm_stb),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr(serr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        reg_addr = idx;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] d);
        reg_addr = idx; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic ecc(input logic ce, input logic ue, input logic [32:0] a,
                       input logic ch, input logic [7:0] s);
        ce_stb = ce; ue_stb = ue; err_addr = a[32:7]; err_chan = ch; err_syn = s;
        tick();
        ce_stb = 1'b0; ue_stb = 1'b0;
    endtask

    task automatic check_log(input string tag, input logic [32:0] a,
                             input logic ch, input logic [7:0] s);
        logic [31:0] v;
        rd(3'd2, v); check({tag, " ptr"}, v, {a[31:7], 6'b0, ch});
        rd(3'd3, v); check({tag, " ext"}, v, {31'b0, a[32]});
        rd(3'd4, v); check({tag, " syn"}, v, {24'b0, s});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            check("R1/R12 reset read", v, 32'h0);
        end
        check("R7 reset serr", 32'(serr), 32'h0);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        rfto_stb = 1'b1; tick(); rfto_stb = 1'b0;
        lock_stb = 1'b1; tick(); lock_stb = 1'b0;
        therm_stb = 1'b1; tick(); therm_stb = 1'b0;
        rd(3'd0, v); check("R1 misc flags", v, 32'h0B00);
        check("R7 serr masked", 32'(serr), 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(3'd0, 16'h0000);
        rd(3'd0, v); check("R2 write zero keeps", v, 32'h0B00);
        wr(3'd0, 16'h0100);
        rd(3'd0, v); check("R2 clear one flag", v, 32'h0A00);
        therm_stb = 1'b1;
        wr(3'd0, 16'h0800);
        therm_stb = 1'b0;
        rd(3'd0, v); check("R2 set wins over clear", v, 32'h0A00);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        wr(3'd1, 16'hFFFF);
        rd(3'd1, v); check("R6 command reserved zero", v, 32'h0B03);
        check("R7 serr enabled", 32'(serr), 32'h1);
        wr(3'd1, 16'h0103);
        check("R7 serr off for masked flags", 32'(serr), 32'h0);
        wr(3'd1, 16'h0200);
        check("R7 serr on lock enable", 32'(serr), 32'h1);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); check("R2 clear all", v, 32'h0);
        check("R7 serr after clear", 32'(serr), 32'h0);
        wr(3'd1, 16'h0000);
    endtask

    task automatic t_ce_log();
        logic [31:0] v;
        ecc(1'b1, 1'b0, 33'h1_2345_67FF, 1'b1, 8'h5A);
        rd(3'd0, v); check("R1 ce flag", v, 32'h0001);
        check_log("R3/R4/R5 ce log", 33'h1_2345_67FF, 1'b1, 8'h5A);
        ecc(1'b1, 1'b0, 33'h0_0000_1280, 1'b0, 8'h33);
        check_log("R10 ce repeat kept", 33'h1_2345_67FF, 1'b1, 8'h5A);
        wr(3'd0, 16'h0001);
        ecc(1'b1, 1'b0, 33'h0_0000_1280, 1'b0, 8'h33);
        check_log("R10 ce after clear", 33'h0_0000_1280, 1'b0, 8'h33);
    endtask

    task automatic t_ue_over();
        logic [31:0] v;
        ecc(1'b0, 1'b1, 33'h1_8000_0100, 1'b1, 8'hC3);
        rd(3'd0, v); check("R8 both flags", v, 32'h0003);
        check_log("R8 ue overwrites ce", 33'h1_8000_0100, 1'b1, 8'hC3);
        wr(3'd0, 16'h0001);
        ecc(1'b1, 1'b0, 33'h0_0000_1280, 1'b0, 8'h33);
        rd(3'd0, v); check("R9 ce flag under ue", v, 32'h0003);
        check_log("R9 ce no log under ue", 33'h1_8000_0100, 1'b1, 8'hC3);
        ecc(1'b0, 1'b1, 33'h0_0000_1280, 1'b0, 8'h33);
        check_log("R10 ue repeat kept", 33'h1_8000_0100, 1'b1, 8'hC3);
        wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF); wr(3'd6, 16'hFFFF);
        check_log("R12 read-only writes", 33'h1_8000_0100, 1'b1, 8'hC3);
        rd(3'd0, v); check("R12 status untouched", v, 32'h0003);
        rd(3'd6, v); check("R12 unused index", v, 32'h0);
        wr(3'd0, 16'hFFFF);
    endtask

    task automatic t_both();
        logic [31:0] v;
        ecc(1'b1, 1'b1, 33'h0_7654_3200, 1'b0, 8'h99);
        rd(3'd0, v); check("R11 both flags", v, 32'h0003);
        check_log("R11 same-cycle log", 33'h0_7654_3200, 1'b0, 8'h99);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_flags();
        t_w1c();
        t_cmd();
        t_ce_log();
        t_ue_over();
        t_both();
        finish_run();
    end
endmodule